// File: doc/BRIEF.md
# Bus Configuration First-Write Capture

This block is the slave bus front end of a serial controller that carries its own DMA engine. After reset, the device does not know how the host bus is wired. The first valid slave write that lands in its address range is therefore not treated as a register write. Its data byte is captured as the bus configuration byte, and the level of the channel-select pin at that moment is captured along with it.

From then on, the captured bits decide how every later access is decoded. They select which address bits form the register index and how the channel is picked. They also set how the DMA engine pulls transmit bytes from a 16-bit bus and which interrupt-acknowledge protocol is in force. The configuration holds until the next reset. The DMA datapath and the interrupt logic sit outside this block and only consume the flags.

Addresses are byte offsets inside the device window. Slave data travels only on the low byte lane, so an access at an odd offset is never valid.

Top module: `bus_cfg_front`

## Requirements
- R1: While reset is asserted and after it is released, `configured`, `reg_wr`, `reg_idx`, `chan_sel` and every configuration flag are 0.
- R2: While `configured` is 0, a write (`wr_en`=1) at an even offset with offset bit 6 = 0 is captured, whatever its other offset bits. `configured` is 1 from the next clock edge. No `reg_wr` is produced for the capture write.
- R3: While `configured` is 0, a write at an odd offset (bit 0 = 1) or with offset bit 6 = 1 is ignored. `configured` stays 0, the flags stay 0 and `reg_wr` stays 0.
- R4: Once configured, `shift_left_mode` equals the inverse of captured data bit 0. When it is 1, `reg_idx` = offset bits 5..1. When it is 0, `reg_idx` = offset bits 4..0. While unconfigured, `reg_idx` is 0.
- R5: `byte_swap` equals captured data bit 7, and `even_low_lane` equals captured data bit 6.
- R6: `intack_double` is 1 only when captured data bits 2..1 are 11.
- R7: `wait_proto` equals the level of `ab_level` in the cycle of the capture write. After that it does not follow `ab_level`.
- R8: Once configured, `chan_sel` equals offset bit 5, and `reg_wr` = `wr_en` for even offsets. While unconfigured, `chan_sel` is 0.
- R9: Writes after the capture do not change any configuration flag or `wait_proto`. Only reset clears them.
- R10: Once configured, a write at an odd offset produces no `reg_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 7 | Byte offset inside the device window |
| wdata | input | 8 | Write data on the low byte lane |
| wr_en | input | 1 | Slave write strobe |
| ab_level | input | 1 | Channel-select pin level, sampled at capture as the wait protocol choice |
| reg_idx | output | 5 | Decoded register index |
| chan_sel | output | 1 | Channel select (offset bit 5 once configured) |
| reg_wr | output | 1 | Normal register write strobe |
| configured | output | 1 | Configuration byte has been captured |
| byte_swap | output | 1 | DMA transmit reads alternate byte lanes |
| even_low_lane | output | 1 | Even-addressed bytes on the low lane |
| intack_double | output | 1 | Double-pulse interrupt acknowledge |
| shift_left_mode | output | 1 | Register index taken from offset bits 5..1 |
| wait_proto | output | 1 | Wait protocol chosen (1) rather than ready (0) |

## Verification
The hardest state to reach is a second configuration attempt on a device that is already configured. Reaching it needs a capture first and then a write that would also qualify for capture. The stimulus performs a capture and then replays a write with offset bit 6 low, an even offset and different data and `ab_level`, so the flags must stay put. Rejected first writes, at odd offsets and in the upper half of the window, are issued before the capture so the gate is exercised while it is still open. Three reset-separated captures cover both index mappings and both interrupt-acknowledge outcomes.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
  localparam int CFG_W        = 8;
  localparam int BIT_SWAP     = 7;
  localparam int BIT_EVEN_LO  = 6;
  localparam int BIT_ACK_HI   = 2;
  localparam int BIT_ACK_LO   = 1;
  localparam int BIT_NO_SHIFT = 0;

  typedef struct packed {
    logic byte_swap;
    logic even_low;
    logic ack_double;
    logic shift_left;
    logic wait_proto;
  } bus_cfg_t;

  function automatic bus_cfg_t unpack_cfg(input logic [CFG_W-1:0] b, input logic ab);
    bus_cfg_t c;
    c.byte_swap  = b[BIT_SWAP];
    c.even_low   = b[BIT_EVEN_LO];
    c.ack_double = b[BIT_ACK_HI] & b[BIT_ACK_LO];
    c.shift_left = ~b[BIT_NO_SHIFT];
    c.wait_proto = ab;
    return c;
  endfunction
endpackage

// File: rtl/bcfg_capture.sv
module bcfg_capture
  import bcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_req,
  input  logic [CFG_W-1:0] cfg_byte,
  input  logic             ab_level,
  output logic             configured,
  output bus_cfg_t         cfg
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_byte[5:3];

  logic cap_fire;
  assign cap_fire = cap_req & ~configured;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      configured <= 1'b0;
      cfg        <= '0;
    end else if (cap_fire) begin
      configured <= 1'b1;
      cfg        <= unpack_cfg(cfg_byte, ab_level);
    end
  end

  // R2
  cap_sets_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> configured);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    configured |=> ($stable(cfg) && configured));
endmodule

// File: rtl/bcfg_decode.sv
module bcfg_decode #(
  parameter int ADDR_W   = 7,
  parameter int IDX_W    = 5,
  parameter int SEL_BIT  = 6,
  parameter int CHAN_BIT = 5
)(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              configured,
  input  logic              shift_left,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              chan_sel,
  output logic              reg_wr,
  output logic              cap_req
);
  logic             even_ok;
  logic [IDX_W-1:0] idx_raw;

  assign even_ok = ~addr[0];

  for (genvar i = 0; i < IDX_W; i++) begin : g_idx
    assign idx_raw[i] = shift_left ? addr[i+1] : addr[i];
  end

  assign reg_idx  = configured ? idx_raw : '0;
  assign chan_sel = configured & addr[CHAN_BIT];
  assign reg_wr   = wr_en & configured & even_ok;
  assign cap_req  = wr_en & ~configured & even_ok & ~addr[SEL_BIT];
endmodule

// File: rtl/bus_cfg_front.sv
module bus_cfg_front
  import bcfg_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int IDX_W    = 5,
  parameter int SEL_BIT  = 6,
  parameter int CHAN_BIT = 5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  input  logic              wr_en,
  input  logic              ab_level,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              chan_sel,
  output logic              reg_wr,
  output logic              configured,
  output logic              byte_swap,
  output logic              even_low_lane,
  output logic              intack_double,
  output logic              shift_left_mode,
  output logic              wait_proto
);
  bus_cfg_t cfg;
  logic     cap_req;

  bcfg_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL_BIT(SEL_BIT), .CHAN_BIT(CHAN_BIT)) u_dec (
    .addr(addr), .wr_en(wr_en), .configured(configured), .shift_left(cfg.shift_left),
    .reg_idx(reg_idx), .chan_sel(chan_sel), .reg_wr(reg_wr), .cap_req(cap_req)
  );

  bcfg_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .cfg_byte(wdata),
    .ab_level(ab_level), .configured(configured), .cfg(cfg)
  );

  assign byte_swap       = cfg.byte_swap;
  assign even_low_lane   = cfg.even_low;
  assign intack_double   = cfg.ack_double;
  assign shift_left_mode = cfg.shift_left;
  assign wait_proto      = cfg.wait_proto;

  // R3
  no_unconf_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !configured |-> !reg_wr);

  // R10
  no_odd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !addr[0]);

  // R3
  reject_stays_unconf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!configured && wr_en && (addr[0] || addr[SEL_BIT])) |=> !configured);
endmodule

// File: tb/tb_bus_cfg_front.sv
module tb_bus_cfg_front;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [6:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr_en = 0, ab_level = 0;
  logic [4:0] reg_idx;
  logic chan_sel, reg_wr, configured, byte_swap, even_low_lane, intack_double, shift_left_mode, wait_proto;

  bus_cfg_front dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  bit m_conf;
  int m_cfg;
  bit m_wait;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(string scen);
    int e_idx;
    if (!m_conf) e_idx = 0;
    else if ((m_cfg & 1) == 0) e_idx = (addr >> 1) & 31;
    else e_idx = addr & 31;
    check({scen, " R2 configured"}, configured, m_conf);
    check({scen, " R8 reg_wr"}, reg_wr, (wr_en && m_conf && !addr[0]) ? 1 : 0);
    check({scen, " R4 reg_idx"}, reg_idx, e_idx);
    check({scen, " R4 shift_left_mode"}, shift_left_mode, m_conf ? (((m_cfg & 1) == 0) ? 1 : 0) : 0);
    check({scen, " R8 chan_sel"}, chan_sel, m_conf ? addr[5] : 0);
    check({scen, " R5 byte_swap"}, byte_swap, (m_cfg >> 7) & 1);
    check({scen, " R5 even_low_lane"}, even_low_lane, (m_cfg >> 6) & 1);
    check({scen, " R6 intack_double"}, intack_double, (((m_cfg >> 1) & 3) == 3) ? 1 : 0);
    check({scen, " R7 wait_proto"}, wait_proto, m_wait);
  endtask

  task automatic cyc(string scen, int a, int d, bit we, bit ab);
    @(negedge clk);
    addr = a[6:0]; wdata = d[7:0]; wr_en = we; ab_level = ab;
    #1;
    compare_all(scen);
    @(posedge clk);
    if (we && !m_conf && !a[0] && !a[6]) begin
      m_conf = 1; m_cfg = d & 255; m_wait = ab;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; addr = 0; wdata = 0; ab_level = 0;
    m_conf = 0; m_cfg = 0; m_wait = 0;
    #1;
    compare_all("R1 in-reset");
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    compare_all("R1 after-release");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3: rejected first writes while the gate is open
    cyc("R3 odd", 7'h05, 8'hC6, 1, 1);
    cyc("R3 upper-half", 7'h44, 8'hC6, 1, 1);
    cyc("R3 upper-half-odd", 7'h7F, 8'hFF, 1, 0);
    cyc("R3 idle", 7'h00, 8'hFF, 0, 1);
    // R2: capture at nonzero offset, data C6, ab high
    cyc("R2 capture", 7'h2A, 8'hC6, 1, 1);
    cyc("R2 post", 7'h00, 8'h00, 0, 0);
    // R4 / R8 shift-left decode, both channels
    cyc("R4 idx5..1 chanA", 7'h3E, 8'h11, 1, 0);
    cyc("R8 chanB", 7'h14, 8'h22, 1, 0);
    cyc("R8 read-only addr", 7'h26, 8'h00, 0, 0);
    // R10 odd offset after configured
    cyc("R10 odd", 7'h2B, 8'h33, 1, 0);
    // R9 second qualifying write must not reconfigure
    cyc("R9 retry", 7'h02, 8'h01, 1, 0);
    cyc("R9 after", 7'h10, 8'h00, 0, 1);
    cyc("R7 ab-follow", 7'h08, 8'h00, 1, 0);

    // second configuration: no shift-left, intack 11, ab low
    do_reset();
    cyc("R2 capture2", 7'h00, 8'h07, 1, 0);
    cyc("R4 idx4..0", 7'h1E, 8'h00, 1, 1);
    cyc("R4 idx4..0 hi", 7'h3C, 8'h00, 1, 1);
    cyc("R10 odd2", 7'h1F, 8'h00, 1, 0);
    cyc("R9 retry2", 7'h04, 8'hC0, 1, 1);

    // third configuration: intack bits 01 -> not double
    do_reset();
    cyc("R3 upper2", 7'h40, 8'h06, 1, 1);
    cyc("R2 capture3", 7'h3A, 8'h42, 1, 1);
    cyc("R6 check", 7'h0C, 8'h00, 1, 0);
    cyc("R5 check", 7'h22, 8'h00, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule